// File: doc/BRIEF.md
# Breakpoint Debug Register Unit

This block holds the debug registers a processor core uses for hardware breakpoints. It also compares every access on the core's access bus against four programmable address slots. Software reaches eight registers through a small indexed port: a 3-bit index, an enable, a write flag and 32-bit write data. Read data comes back from a register one cycle after the read strobe. Indices 0 to 3 hold the slot addresses, index 6 is the status register and index 7 is the control register. The meaning of indices 4 and 5 depends on the debug-extensions enable input.

Each slot has two enable bits and a 2-bit access-type code in the control register. A slot fires when the access is valid, the access kind fits the code, and the address is identical to the slot address. A hit raises a one-cycle pulse and sets that slot's bit in the status register. The bit stays set until software writes the status register. An index that is illegal while extensions are on produces a one-cycle invalid-opcode fault pulse instead of a register access.

Top module: `hwbp_unit`

## Requirements
- R1: After reset the control register reads 32'h0000_0000 and the status register reads 32'hFFFF_0FF0. `reg_rdata`, `bp_hit`, `ud_fault` and `bp_slot_stat` are all zero.
- R2: Indices 0, 1, 2 and 3 each store a full 32-bit slot address (slot n at index n), and a read returns the last value written.
- R3: Control register bits 11, 12, 14 and 15 always read as zero, whatever was written to them. All other control bits keep the written value.
- R4: Status register bit 12 always reads as zero, even after a write of 1. All other status bits take the written value.
- R5: With `dbg_ext_en` low, index 4 behaves exactly as index 6 and index 5 behaves exactly as index 7, for both reads and writes.
- R6: With `dbg_ext_en` high, a read or write at index 4 or 5 raises `ud_fault` for exactly the following cycle and modifies no register. When the access is a read, `reg_rdata` becomes zero.
- R7: Access-type code 2'b00 (slot n: control bits 16+4n and 17+4n, bit 16+4n being the low bit) matches only instruction fetches (`acc_kind` 3'd0).
- R8: Access-type code 2'b01 matches only data writes (`acc_kind` 3'd2).
- R9: Access-type code 2'b11 matches data reads (`acc_kind` 3'd1) and data writes, and matches no fetch and no I/O access.
- R10: Access-type code 2'b10 matches I/O reads (`acc_kind` 3'd3) and I/O writes (`acc_kind` 3'd4) only when `dbg_ext_en` is high. With `dbg_ext_en` low, a slot holding this code never hits.
- R11: A slot hits only if its local enable (control bit 2n) or its global enable (bit 2n+1) is set, `acc_valid` is high, and `acc_addr` equals the slot address in every bit.
- R12: A hit raises `bp_hit` for the single cycle after the access and sets status bit n. That bit remains set until a status-register write. A hit in the same cycle as a status write still leaves its bit set.
- R13: `reg_rdata` is updated one cycle after a read strobe and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_ext_en | input | 1 | Debug-extensions enable |
| reg_en | input | 1 | Register port strobe |
| reg_wr | input | 1 | 1 = write, 0 = read (qualified by `reg_en`) |
| reg_idx | input | 3 | Register index 0..7 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| acc_valid | input | 1 | Access bus valid |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 3 | 0 fetch, 1 data read, 2 data write, 3 I/O read, 4 I/O write |
| bp_hit | output | 1 | One-cycle breakpoint hit pulse |
| bp_slot_stat | output | 4 | Sticky per-slot status bits (status bits 3:0) |
| ud_fault | output | 1 | One-cycle invalid-opcode fault pulse |

## Verification
The bench drives all five access kinds at all four codes, once with the extensions enable low and once with it high. A design that let code 2'b10 match I/O while the enable is low, or that let a fetch through code 2'b11, would raise spurious hits there. It writes all ones to the control and status registers, which would expose a reserved bit that sticks. It also drives indices 4 and 5 in both enable states, so an alias that keeps working while the enable is high, or a faulting write that still updates a register, would show up in later reads. Separate tests cover an address one off from a slot, a hit in the same cycle as a status clear, and idle cycles after a hit. These would catch a loose comparator, a status write that beats the hit, and status bits that decay on their own.

// File: rtl/hwbp_pkg.sv
package hwbp_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int REG_W     = 32;
    localparam int IDX_W     = 3;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int EN_STRIDE = 2;
    localparam int RW_BASE   = 16;
    localparam int RW_STRIDE = 4;

    // bits forced to zero in control (11,12,14,15) and status (12)
    localparam logic [REG_W-1:0] CTRL_ZERO_MASK = 32'h0000_D800;
    localparam logic [REG_W-1:0] STAT_ZERO_MASK = 32'h0000_1000;
    localparam logic [REG_W-1:0] STAT_RESET     = 32'hFFFF_0FF0 & ~STAT_ZERO_MASK;

    typedef enum logic [2:0] {
        KIND_FETCH = 3'd0,
        KIND_DRD   = 3'd1,
        KIND_DWR   = 3'd2,
        KIND_IORD  = 3'd3,
        KIND_IOWR  = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        RW_EXEC  = 2'b00,
        RW_WRITE = 2'b01,
        RW_IO    = 2'b10,
        RW_DATA  = 2'b11
    } rw_code_e;

    typedef enum logic [1:0] {
        SEL_ADDR,
        SEL_STAT,
        SEL_CTRL,
        SEL_TRAP
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [SLOT_W-1:0] slot;
    } reg_req_t;

    typedef struct packed {
        logic             valid;
        acc_kind_e        kind;
        logic [REG_W-1:0] addr;
    } acc_t;

    function automatic logic kind_matches(rw_code_e code, acc_kind_e kind, logic ext_en);
        logic m;
        m = 1'b0;
        case (code)
            RW_EXEC:  m = (kind == KIND_FETCH);
            RW_WRITE: m = (kind == KIND_DWR);
            RW_DATA:  m = (kind == KIND_DRD) || (kind == KIND_DWR);
            RW_IO:    m = ext_en && ((kind == KIND_IORD) || (kind == KIND_IOWR));
            default:  m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hwbp_idx_decode.sv
module hwbp_idx_decode
    import hwbp_pkg::*;
(
    input  logic             reg_en,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             ext_en,
    output reg_req_t         req
);

    always_comb begin
        req.rd   = reg_en & ~reg_wr;
        req.wr   = reg_en & reg_wr;
        req.slot = reg_idx[SLOT_W-1:0];
        case (reg_idx)
            IDX_W'(4): req.sel = ext_en ? SEL_TRAP : SEL_STAT;
            IDX_W'(5): req.sel = ext_en ? SEL_TRAP : SEL_CTRL;
            IDX_W'(6): req.sel = SEL_STAT;
            IDX_W'(7): req.sel = SEL_CTRL;
            default:   req.sel = SEL_ADDR;
        endcase
    end

endmodule

// File: rtl/hwbp_regbank.sv
module hwbp_regbank
    import hwbp_pkg::*;
#(
    parameter int NS = NUM_SLOTS,
    parameter int DW = REG_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_req_t             req,
    input  logic [DW-1:0]        wdata,
    input  logic [NS-1:0]        hit_set,
    output logic [NS-1:0][DW-1:0] slot_addr,
    output logic [NS-1:0][1:0]   slot_en,
    output logic [NS-1:0][1:0]   slot_rw,
    output logic [NS-1:0]        stat_bits,
    output logic [DW-1:0]        rdata_q,
    output logic                 trap_q
);

    localparam logic [DW-1:0] CMASK = DW'(CTRL_ZERO_MASK);
    localparam logic [DW-1:0] SMASK = DW'(STAT_ZERO_MASK);
    localparam logic [DW-1:0] SRST  = DW'(STAT_RESET);

    logic [DW-1:0] addr_q [NS];
    logic [DW-1:0] ctrl_q, stat_q;
    logic [DW-1:0] ctrl_d, stat_d, rd_mux;

    for (genvar g = 0; g < NS; g++) begin : g_addr
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[g] <= '0;
            end else if (req.wr && req.sel == SEL_ADDR && req.slot == SLOT_W'(g)) begin
                addr_q[g] <= wdata;
            end
        end
        assign slot_addr[g] = addr_q[g];
        assign slot_en[g]   = ctrl_q[EN_STRIDE*g +: 2];
        assign slot_rw[g]   = ctrl_q[RW_BASE + RW_STRIDE*g +: 2];
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (req.wr && req.sel == SEL_CTRL) begin
            ctrl_d = wdata & ~CMASK;
        end
    end

    // a hit in the same cycle as a status write still lands
    always_comb begin
        stat_d = stat_q;
        if (req.wr && req.sel == SEL_STAT) begin
            stat_d = wdata & ~SMASK;
        end
        stat_d[NS-1:0] = stat_d[NS-1:0] | hit_set;
    end

    always_comb begin
        case (req.sel)
            SEL_ADDR: rd_mux = addr_q[req.slot];
            SEL_STAT: rd_mux = stat_q;
            SEL_CTRL: rd_mux = ctrl_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            stat_q  <= SRST;
            rdata_q <= '0;
            trap_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
            trap_q <= (req.rd | req.wr) && (req.sel == SEL_TRAP);
            if (req.rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign stat_bits = stat_q[NS-1:0];

endmodule

// File: rtl/hwbp_slot.sv
module hwbp_slot
    import hwbp_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic [1:0]    en_bits,
    input  rw_code_e      code,
    input  logic [DW-1:0] base,
    input  acc_t          acc,
    input  logic          ext_en,
    output logic          hit
);

    logic kind_ok, addr_ok;

    assign kind_ok = kind_matches(code, acc.kind, ext_en);
    assign addr_ok = (acc.addr == base);
    assign hit     = (|en_bits) && acc.valid && kind_ok && addr_ok;

endmodule

// File: rtl/hwbp_unit.sv
module hwbp_unit
    import hwbp_pkg::*;
#(
    parameter int NSLOTS = NUM_SLOTS,
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_ext_en,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [DATA_W-1:0] acc_addr,
    input  logic [2:0]        acc_kind,
    output logic              bp_hit,
    output logic [NSLOTS-1:0] bp_slot_stat,
    output logic              ud_fault
);

    reg_req_t                    req;
    acc_t                        acc;
    logic [NSLOTS-1:0][DATA_W-1:0] slot_addr;
    logic [NSLOTS-1:0][1:0]      slot_en;
    logic [NSLOTS-1:0][1:0]      slot_rw;
    logic [NSLOTS-1:0]           hit_vec;
    logic                        hit_q;

    hwbp_idx_decode u_dec (
        .reg_en  (reg_en),
        .reg_wr  (reg_wr),
        .reg_idx (reg_idx),
        .ext_en  (dbg_ext_en),
        .req     (req)
    );

    hwbp_regbank #(.NS(NSLOTS), .DW(DATA_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wdata     (reg_wdata),
        .hit_set   (hit_vec),
        .slot_addr (slot_addr),
        .slot_en   (slot_en),
        .slot_rw   (slot_rw),
        .stat_bits (bp_slot_stat),
        .rdata_q   (reg_rdata),
        .trap_q    (ud_fault)
    );

    always_comb begin
        acc.valid = acc_valid;
        acc.kind  = acc_kind_e'(acc_kind);
        acc.addr  = REG_W'(acc_addr);
    end

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        hwbp_slot #(.DW(DATA_W)) u_slot (
            .en_bits (slot_en[s]),
            .code    (rw_code_e'(slot_rw[s])),
            .base    (slot_addr[s]),
            .acc     (acc),
            .ext_en  (dbg_ext_en),
            .hit     (hit_vec[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= |hit_vec;
        end
    end

    assign bp_hit = hit_q;

endmodule

// File: rtl/hwbp_unit_chk.sv
module hwbp_unit_chk #(
    parameter int NSLOTS = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dbg_ext_en,
    input logic              reg_en,
    input logic              reg_wr,
    input logic [2:0]        reg_idx,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              acc_valid,
    input logic              bp_hit,
    input logic [NSLOTS-1:0] bp_slot_stat,
    input logic              ud_fault
);

    logic stat_wr;
    assign stat_wr = reg_en && reg_wr &&
                     (reg_idx == 3'd6 || (reg_idx == 3'd4 && !dbg_ext_en));

    p_fault_cause_r6: assert property (@(posedge clk) disable iff (rst)
        ud_fault |-> $past(reg_en && dbg_ext_en && reg_idx[2:1] == 2'b10));

    p_fault_rdata_r6: assert property (@(posedge clk) disable iff (rst)
        (ud_fault && $past(!reg_wr)) |-> (reg_rdata == '0));

    p_ctrl_rsvd_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_wr && reg_idx == 3'd7)
        |=> (reg_rdata[11] == 1'b0 && reg_rdata[12] == 1'b0 &&
             reg_rdata[14] == 1'b0 && reg_rdata[15] == 1'b0));

    p_stat_bit12_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_wr && reg_idx == 3'd6) |=> (reg_rdata[12] == 1'b0));

    p_hit_needs_valid_r11: assert property (@(posedge clk) disable iff (rst)
        bp_hit |-> $past(acc_valid));

    p_hit_sets_stat_r12: assert property (@(posedge clk) disable iff (rst)
        bp_hit |-> (bp_slot_stat != '0));

    p_stat_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((bp_slot_stat & $past(bp_slot_stat)) == $past(bp_slot_stat)));

    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !(reg_en && !reg_wr) |=> $stable(reg_rdata));

endmodule

bind hwbp_unit hwbp_unit_chk #(.NSLOTS(NSLOTS), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dbg_ext_en   (dbg_ext_en),
    .reg_en       (reg_en),
    .reg_wr       (reg_wr),
    .reg_idx      (reg_idx),
    .reg_rdata    (reg_rdata),
    .acc_valid    (acc_valid),
    .bp_hit       (bp_hit),
    .bp_slot_stat (bp_slot_stat),
    .ud_fault     (ud_fault)
);

// File: tb/sim_hwbp_unit.sv
`timescale 1ns/1ps
module sim_hwbp_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_ext_en = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_kind = '0;
    logic        bp_hit;
    logic [3:0]  bp_slot_stat;
    logic        ud_fault;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    // bench model of the programmer-visible state
    logic [31:0] m_addr [4];
    logic [31:0] m_ctrl, m_stat, m_rdata;
    logic        m_fault, m_hit;

    always #10 clk = ~clk;

    hwbp_unit u0 (
        .clk          (clk),
        .rst          (rst),
        .dbg_ext_en   (dbg_ext_en),
        .reg_en       (reg_en),
        .reg_wr       (reg_wr),
        .reg_idx      (reg_idx),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .acc_valid    (acc_valid),
        .acc_addr     (acc_addr),
        .acc_kind     (acc_kind),
        .bp_hit       (bp_hit),
        .bp_slot_stat (bp_slot_stat),
        .ud_fault     (ud_fault)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_slot_hit(int n, logic [31:0] a, logic [2:0] k, logic de);
        logic en, ok;
        logic [1:0] t;
        en = m_ctrl[2*n] | m_ctrl[2*n+1];
        t  = m_ctrl[16+4*n +: 2];
        case (t)
            2'b00:   ok = (k == 3'd0);
            2'b01:   ok = (k == 3'd2);
            2'b11:   ok = (k == 3'd1) || (k == 3'd2);
            default: ok = de && ((k == 3'd3) || (k == 3'd4));
        endcase
        return en && ok && (a == m_addr[n]);
    endfunction

    function automatic logic [31:0] mread(logic [2:0] i);
        if (i < 3'd4) return m_addr[i[1:0]];
        if (i == 3'd6) return m_stat;
        return m_ctrl;
    endfunction

    // one cycle: drive at a falling edge, check at the next falling edge
    task automatic op(input logic de, input logic en, input logic wr, input logic [2:0] idx,
                      input logic [31:0] wd, input logic av, input logic [31:0] aa,
                      input logic [2:0] ak, input string tag);
        logic [3:0] hits;
        logic [2:0] eff;
        logic       trap;
        dbg_ext_en = de; reg_en = en; reg_wr = wr; reg_idx = idx; reg_wdata = wd;
        acc_valid = av; acc_addr = aa; acc_kind = ak;
        for (int s = 0; s < 4; s++) hits[s] = av && exp_slot_hit(s, aa, ak, de);
        trap = en && de && (idx == 3'd4 || idx == 3'd5);
        eff  = (idx == 3'd4) ? 3'd6 : (idx == 3'd5) ? 3'd7 : idx;
        if (en && !wr) m_rdata = trap ? 32'h0 : mread(eff);
        if (en && wr && !trap) begin
            if (eff < 3'd4) m_addr[eff[1:0]] = wd;
            else if (eff == 3'd6) m_stat = wd & ~32'h0000_1000;
            else m_ctrl = wd & ~32'h0000_D800;
        end
        m_stat[3:0] = m_stat[3:0] | hits;
        m_fault = trap;
        m_hit = |hits;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0; acc_valid = 1'b0;
        chk(tag, "rdata", reg_rdata, m_rdata);
        chk(tag, "fault", 32'(ud_fault), 32'(m_fault));
        chk(tag, "hit",   32'(bp_hit), 32'(m_hit));
        chk(tag, "stat",  32'(bp_slot_stat), 32'(m_stat[3:0]));
    endtask

    task automatic wr_reg(input logic de, input logic [2:0] i, input logic [31:0] d, input string tag);
        op(de, 1'b1, 1'b1, i, d, 1'b0, 32'h0, 3'd0, tag);
    endtask

    task automatic rd_reg(input logic de, input logic [2:0] i, input string tag);
        op(de, 1'b1, 1'b0, i, 32'h0, 1'b0, 32'h0, 3'd0, tag);
    endtask

    task automatic access(input logic de, input logic [31:0] a, input logic [2:0] k, input string tag);
        op(de, 1'b0, 1'b0, 3'd0, 32'h0, 1'b1, a, k, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        string tags [4];
        tags[0] = "R7"; tags[1] = "R8"; tags[2] = "R9"; tags[3] = "R10";
        for (int s = 0; s < 4; s++) m_addr[s] = 32'h0;
        m_ctrl = 32'h0; m_stat = 32'hFFFF_0FF0; m_rdata = 32'h0;
        m_fault = 1'b0; m_hit = 1'b0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rdata", reg_rdata, 32'h0);
        chk("R1", "hit",   32'(bp_hit), 32'h0);
        chk("R1", "fault", 32'(ud_fault), 32'h0);
        chk("R1", "stat",  32'(bp_slot_stat), 32'h0);
        rd_reg(1'b0, 3'd7, "R1");
        chk("R1", "ctrl reset", reg_rdata, 32'h0000_0000);
        rd_reg(1'b0, 3'd6, "R1");
        chk("R1", "stat reset", reg_rdata, 32'hFFFF_0FF0);

        // R2 address registers
        for (int i = 0; i < 4; i++) wr_reg(1'b0, 3'(i), 32'hA5A5_0000 + 32'(i * 32'h1111), "R2");
        for (int i = 0; i < 4; i++) rd_reg(1'b0, 3'(i), "R2");
        chk("R2", "addr3", reg_rdata, 32'hA5A5_3333);

        // R3 control reserved bits; R13 read data holds across a write
        wr_reg(1'b0, 3'd7, 32'hFFFF_FFFF, "R3");
        chk("R13", "rdata hold", reg_rdata, 32'hA5A5_3333);
        rd_reg(1'b0, 3'd7, "R3");
        chk("R3", "ctrl ones", reg_rdata, 32'hFFFF_27FF);
        wr_reg(1'b0, 3'd7, 32'h0, "R3");

        // R4 status bit 12
        wr_reg(1'b0, 3'd6, 32'hFFFF_FFFF, "R4");
        rd_reg(1'b0, 3'd6, "R4");
        chk("R4", "stat ones", reg_rdata, 32'hFFFF_EFFF);

        // R5 aliases with extensions off
        wr_reg(1'b0, 3'd4, 32'h1234_5678, "R5");
        rd_reg(1'b0, 3'd6, "R5");
        chk("R5", "alias 4->6", reg_rdata, 32'h1234_4678);
        wr_reg(1'b0, 3'd5, 32'h0003_0001, "R5");
        rd_reg(1'b0, 3'd7, "R5");
        chk("R5", "alias 5->7", reg_rdata, 32'h0003_0001);
        rd_reg(1'b0, 3'd4, "R5");
        rd_reg(1'b0, 3'd5, "R5");

        // R6 traps with extensions on
        wr_reg(1'b1, 3'd4, 32'h0, "R6");
        chk("R6", "fault on write", 32'(ud_fault), 32'h1);
        rd_reg(1'b1, 3'd6, "R6");
        chk("R6", "stat untouched", reg_rdata, 32'h1234_4678);
        wr_reg(1'b1, 3'd5, 32'hFFFF_FFFF, "R6");
        rd_reg(1'b1, 3'd5, "R6");
        chk("R6", "rdata zero", reg_rdata, 32'h0);
        chk("R6", "fault on read", 32'(ud_fault), 32'h1);
        rd_reg(1'b1, 3'd7, "R6");
        chk("R6", "ctrl untouched", reg_rdata, 32'h0003_0001);
        chk("R6", "fault one cycle", 32'(ud_fault), 32'h0);

        // R7..R10 access-type codes, both enable states
        for (int s = 0; s < 4; s++) wr_reg(1'b0, 3'(s), 32'h1000 * 32'(s + 1), "R2");
        wr_reg(1'b0, 3'd7, 32'h0000_00AA | (32'h1 << 20) | (32'h3 << 24) | (32'h2 << 28), "R3");
        for (int de = 0; de < 2; de++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 5; k++) begin
                    wr_reg(1'b0, 3'd6, 32'h0, tags[s]);
                    access(1'(de), 32'h1000 * 32'(s + 1), 3'(k), tags[s]);
                end
        wr_reg(1'b0, 3'd6, 32'h0, "R10");
        access(1'b0, 32'h4000, 3'd3, "R10");
        chk("R10", "io code off", 32'(bp_hit), 32'h0);
        access(1'b1, 32'h4000, 3'd4, "R10");
        chk("R10", "io code on", 32'(bp_hit), 32'h1);

        // R11 enables, exact address, valid
        wr_reg(1'b0, 3'd6, 32'h0, "R11");
        wr_reg(1'b0, 3'd7, 32'h0000_0001, "R11");
        access(1'b0, 32'h1000, 3'd0, "R11");
        chk("R11", "local enable", 32'(bp_hit), 32'h1);
        wr_reg(1'b0, 3'd7, 32'h0, "R11");
        access(1'b0, 32'h1000, 3'd0, "R11");
        chk("R11", "disabled", 32'(bp_hit), 32'h0);
        wr_reg(1'b0, 3'd7, 32'h0000_0002, "R11");
        access(1'b0, 32'h1001, 3'd0, "R11");
        chk("R11", "addr off by one", 32'(bp_hit), 32'h0);
        access(1'b0, 32'h0000_1000 | 32'h8000_0000, 3'd0, "R11");
        op(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 32'h1000, 3'd0, "R11");
        chk("R11", "not valid", 32'(bp_hit), 32'h0);

        // R12 sticky status, pulse width, same-cycle write and hit
        wr_reg(1'b0, 3'd6, 32'h0, "R12");
        access(1'b0, 32'h1000, 3'd0, "R12");
        chk("R12", "stat set", 32'(bp_slot_stat), 32'h1);
        for (int i = 0; i < 3; i++) op(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 3'd0, "R12");
        chk("R12", "pulse ended", 32'(bp_hit), 32'h0);
        chk("R12", "stat sticky", 32'(bp_slot_stat), 32'h1);
        wr_reg(1'b0, 3'd6, 32'h0, "R12");
        chk("R12", "stat cleared", 32'(bp_slot_stat), 32'h0);
        op(1'b0, 1'b1, 1'b1, 3'd6, 32'h0, 1'b1, 32'h1000, 3'd0, "R12");
        chk("R12", "hit beats clear", 32'(bp_slot_stat), 32'h1);

        // constrained random mix against the model
        void'($urandom(32'd7319));
        begin
            logic de_r;
            de_r = 1'b0;
            for (int n = 0; n < 3000; n++) begin
                int sel;
                logic [31:0] d, a;
                if ($urandom_range(0, 15) == 0) de_r = ~de_r;
                sel = $urandom_range(0, 9);
                if (sel < 3) begin
                    logic [2:0] i;
                    i = 3'($urandom_range(0, 7));
                    d = $urandom();
                    if ((i == 3'd7 || i == 3'd5) && $urandom_range(0, 1) == 1) d[7:0] = 8'hFF;
                    if (i < 3'd4) d = {20'h0, d[11:0]};
                    wr_reg(de_r, i, d, "R13");
                end else if (sel < 6) begin
                    rd_reg(de_r, 3'($urandom_range(0, 7)), "R13");
                end else begin
                    a = $urandom_range(0, 1) ? m_addr[$urandom_range(0, 3)] : {20'h0, 12'($urandom())};
                    access(de_r, a, 3'($urandom_range(0, 4)), "R12");
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule